// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block owns a processor status word and turns its four power-mode bits into enable lines for the CPU, the main clock, the subsystem clock, the auxiliary clock, the fast oscillator, that oscillator's DC generator and the crystal. Software sets a power level by writing the status word. The block decodes the word into one of five levels: active, or low-power level 0 to 4. Each level switches off a larger part of the clock tree than the one before it.

An interrupt request that the current level allows wakes the block. On that interrupt it hands out the old status word as the saved copy. In the live word it clears the CPU-off, oscillator-off and SCG1 bits and the global interrupt enable. SCG0 is left as it was. On return from interrupt, the word on the return port is loaded whole. Whatever power level that word encodes, possibly edited by the service routine, drives the enables from the next cycle on. A one-bit input tells the block whether the fast oscillator feeds the main or subsystem clock, which settles the DC generator in level 1.

Top module: `lpm_clock_gate`

## Requirements
- R1: After reset the status word is 0x0000, every enable output is 1 and `irqAck` is 0.
- R2: Status bits: 3 = global interrupt enable, 4 = CPU off, 5 = oscillator off, 6 = SCG0, 7 = SCG1. With bit 4 clear, every enable is 1 whatever bits 5 to 7 hold.
- R3: Level 0 (bit 4 set, bits 5, 6, 7 clear) turns off `cpuEn` and `mclkEn` and keeps the other five enables on.
- R4: Level 1 (bits 4 and 6 set, bits 5 and 7 clear) behaves like level 0, except that `dcGenEn` equals `dcoSrcUsed`.
- R5: Level 2 (bits 4 and 7 set, bits 5 and 6 clear) leaves only `aclkEn`, `dcGenEn` and `xtalEn` on.
- R6: Level 3 (bits 4, 6 and 7 set, bit 5 clear) leaves only `aclkEn` and `xtalEn` on.
- R7: Level 4 (bits 4 and 5 set, bits 6 and 7 any value) turns off every enable.
- R8: When bit 3 is set and an allowed request is present at a clock edge, three things happen after that edge. `savedWord` holds the previous status word. The status word equals the previous word with bits 3, 4, 5 and 7 cleared and all other bits kept, SCG0 included. `irqAck` is 1 for that single cycle.
- R9: In level 4, `irqReq` alone is ignored: the status word stays unchanged and `irqAck` stays 0. `irqExtReq` still wakes the block.
- R10: With bit 3 clear, no request is taken: the status word stays unchanged and `irqAck` stays 0.
- R11: A return pulse loads `retiWord` into the status word on the next edge, and the enables follow the level it encodes.
- R12: A software write loads `swWrData` into the status word on the next edge. An interrupt entry in the same cycle wins over a return, and a return wins over a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swWrEn | input | 1 | Software write of the status word |
| swWrData | input | 16 | Status word to write |
| retiEn | input | 1 | Return-from-interrupt pulse |
| retiWord | input | 16 | Status word restored on return |
| irqReq | input | 1 | Enabled request from any source |
| irqExtReq | input | 1 | Enabled request from an external pin |
| dcoSrcUsed | input | 1 | Fast oscillator feeds the main or subsystem clock |
| statusWord | output | 16 | Live status word |
| savedWord | output | 16 | Status word captured at interrupt entry |
| irqAck | output | 1 | One-cycle pulse when an interrupt is taken |
| cpuEn | output | 1 | CPU run enable |
| mclkEn | output | 1 | Main clock enable |
| smclkEn | output | 1 | Subsystem clock enable |
| aclkEn | output | 1 | Auxiliary clock enable |
| dcoEn | output | 1 | Fast oscillator enable |
| dcGenEn | output | 1 | Oscillator DC generator enable |
| xtalEn | output | 1 | Crystal oscillator enable |

## Verification
The decoder is driven with each of the five level codes, and also with mode bits set while CPU-off is clear. That second pattern shows whether active mode is decided by bit 4 alone. Level 1 is run with both values of `dcoSrcUsed`, which is the only way to tell level 1 apart from level 0. Interrupt entry starts from a word that has SCG0, a flag bit and GIE set. This shows whether the right bits are cleared, the others kept and the old word saved. Level 4 receives both request classes, and a word with GIE clear receives both as well. Together these separate the wake gating by class from the gating by enable. A return with an edited word shows whether the restored level takes effect at once.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int WORD_W  = 16;
  localparam int GIE_BIT = 3;
  localparam int CPU_BIT = 4;
  localparam int OSC_BIT = 5;
  localparam int SG0_BIT = 6;
  localparam int SG1_BIT = 7;

  typedef enum logic [2:0] {
    LVL_ACTIVE = 3'd0,
    LVL_0      = 3'd1,
    LVL_1      = 3'd2,
    LVL_2      = 3'd3,
    LVL_3      = 3'd4,
    LVL_4      = 3'd5
  } powerLevel_t;

  typedef struct packed {
    logic enter;
    logic restore;
    logic write;
  } ctrlStrobes_t;

  function automatic powerLevel_t decodeLevel(input logic cpuOff, input logic oscOff,
                                              input logic scg0, input logic scg1);
    if (!cpuOff)     return LVL_ACTIVE;
    else if (oscOff) return LVL_4;
    else begin
      case ({scg1, scg0})
        2'b00:   return LVL_0;
        2'b01:   return LVL_1;
        2'b10:   return LVL_2;
        default: return LVL_3;
      endcase
    end
  endfunction
endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  powerLevel_t  curLevel,
  input  logic         gie,
  input  logic         irqReq,
  input  logic         irqExtReq,
  input  logic         retiEn,
  input  logic         swWrEn,
  output ctrlStrobes_t strobes,
  output logic         irqAck
);
  logic wakeAllowed;
  logic accept;

  // level 4 listens to the external class only
  always_comb begin
    if (curLevel == LVL_4) wakeAllowed = irqExtReq;
    else                   wakeAllowed = irqReq || irqExtReq;
    accept = gie && wakeAllowed;
  end

  always_comb begin
    strobes.enter   = accept;
    strobes.restore = retiEn && !accept;
    strobes.write   = swWrEn && !accept && !retiEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqAck <= 1'b0;
    else       irqAck <= accept;
  end

  AST_LPM4_EXT_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (curLevel == LVL_4 && !irqExtReq) |=> !irqAck); // R9

  AST_NO_GIE_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !gie |=> !irqAck); // R10

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobes.enter, strobes.restore, strobes.write}) <= 1); // R12
endmodule

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic [W-1:0] swWrData,
  input  logic [W-1:0] retiWord,
  input  logic         dcoSrcUsed,
  output logic [W-1:0] statusWord,
  output logic [W-1:0] savedWord,
  output powerLevel_t  curLevel,
  output logic         gie,
  output logic         cpuEn,
  output logic         mclkEn,
  output logic         smclkEn,
  output logic         aclkEn,
  output logic         dcoEn,
  output logic         dcGenEn,
  output logic         xtalEn
);
  localparam logic [W-1:0] ENTRY_CLR =
    (W'(1) << GIE_BIT) | (W'(1) << CPU_BIT) | (W'(1) << OSC_BIT) | (W'(1) << SG1_BIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusWord <= '0;
      savedWord  <= '0;
    end else if (strobes.enter) begin
      savedWord  <= statusWord;
      statusWord <= statusWord & ~ENTRY_CLR;
    end else if (strobes.restore) begin
      statusWord <= retiWord;
    end else if (strobes.write) begin
      statusWord <= swWrData;
    end
  end

  always_comb begin
    curLevel = decodeLevel(statusWord[CPU_BIT], statusWord[OSC_BIT],
                           statusWord[SG0_BIT], statusWord[SG1_BIT]);
    gie = statusWord[GIE_BIT];
  end

  always_comb begin
    cpuEn   = 1'b1;
    mclkEn  = 1'b1;
    smclkEn = 1'b1;
    aclkEn  = 1'b1;
    dcoEn   = 1'b1;
    dcGenEn = 1'b1;
    xtalEn  = 1'b1;
    case (curLevel)
      LVL_ACTIVE: ;
      LVL_0: begin
        cpuEn = 1'b0; mclkEn = 1'b0;
      end
      LVL_1: begin
        cpuEn = 1'b0; mclkEn = 1'b0; dcGenEn = dcoSrcUsed;
      end
      LVL_2: begin
        cpuEn = 1'b0; mclkEn = 1'b0; smclkEn = 1'b0; dcoEn = 1'b0;
      end
      LVL_3: begin
        cpuEn = 1'b0; mclkEn = 1'b0; smclkEn = 1'b0; dcoEn = 1'b0; dcGenEn = 1'b0;
      end
      default: begin
        cpuEn = 1'b0; mclkEn = 1'b0; smclkEn = 1'b0; aclkEn = 1'b0;
        dcoEn = 1'b0; dcGenEn = 1'b0; xtalEn = 1'b0;
      end
    endcase
  end

  AST_ENTRY_SAVES: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enter |=> savedWord == $past(statusWord)); // R8

  AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enter |=> (statusWord[CPU_BIT] == 1'b0 && statusWord[OSC_BIT] == 1'b0 &&
                       statusWord[SG1_BIT] == 1'b0 && statusWord[GIE_BIT] == 1'b0)); // R8

  AST_SCG0_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enter |=> statusWord[SG0_BIT] == $past(statusWord[SG0_BIT])); // R8

  AST_RETI_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restore |=> statusWord == $past(retiWord)); // R11
endmodule

// File: rtl/lpm_clock_gate.sv
module lpm_clock_gate
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              swWrEn,
  input  logic [WORD_W-1:0] swWrData,
  input  logic              retiEn,
  input  logic [WORD_W-1:0] retiWord,
  input  logic              irqReq,
  input  logic              irqExtReq,
  input  logic              dcoSrcUsed,
  output logic [WORD_W-1:0] statusWord,
  output logic [WORD_W-1:0] savedWord,
  output logic              irqAck,
  output logic              cpuEn,
  output logic              mclkEn,
  output logic              smclkEn,
  output logic              aclkEn,
  output logic              dcoEn,
  output logic              dcGenEn,
  output logic              xtalEn
);
  ctrlStrobes_t strobes;
  powerLevel_t  curLevel;
  logic         gie;

  lpm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .curLevel(curLevel), .gie(gie),
    .irqReq(irqReq), .irqExtReq(irqExtReq), .retiEn(retiEn), .swWrEn(swWrEn),
    .strobes(strobes), .irqAck(irqAck)
  );

  lpm_datapath #(.W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .swWrData(swWrData),
    .retiWord(retiWord), .dcoSrcUsed(dcoSrcUsed), .statusWord(statusWord),
    .savedWord(savedWord), .curLevel(curLevel), .gie(gie), .cpuEn(cpuEn),
    .mclkEn(mclkEn), .smclkEn(smclkEn), .aclkEn(aclkEn), .dcoEn(dcoEn),
    .dcGenEn(dcGenEn), .xtalEn(xtalEn)
  );
endmodule

// File: tb/lpm_clock_gate_bench.sv
module lpm_clock_gate_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swWrEn = 1'b0;
  logic [15:0] swWrData = '0;
  logic retiEn = 1'b0;
  logic [15:0] retiWord = '0;
  logic irqReq = 1'b0;
  logic irqExtReq = 1'b0;
  logic dcoSrcUsed = 1'b0;
  logic [15:0] statusWord, savedWord;
  logic irqAck, cpuEn, mclkEn, smclkEn, aclkEn, dcoEn, dcGenEn, xtalEn;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  lpm_clock_gate u_lpm_clock_gate (
    .clk(clk), .rstN(rstN), .swWrEn(swWrEn), .swWrData(swWrData),
    .retiEn(retiEn), .retiWord(retiWord), .irqReq(irqReq), .irqExtReq(irqExtReq),
    .dcoSrcUsed(dcoSrcUsed), .statusWord(statusWord), .savedWord(savedWord),
    .irqAck(irqAck), .cpuEn(cpuEn), .mclkEn(mclkEn), .smclkEn(smclkEn),
    .aclkEn(aclkEn), .dcoEn(dcoEn), .dcGenEn(dcGenEn), .xtalEn(xtalEn)
  );

  task automatic checkVal(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // order: cpu, mclk, smclk, aclk, dco, dcgen, xtal
  task automatic checkEn(input string tag, input logic [6:0] exp);
    checkVal(tag, {9'd0, cpuEn, mclkEn, smclkEn, aclkEn, dcoEn, dcGenEn, xtalEn}, {9'd0, exp});
  endtask

  task automatic writeWord(input logic [15:0] w);
    @(negedge clk); swWrEn = 1'b1; swWrData = w;
    @(negedge clk); swWrEn = 1'b0;
  endtask

  task automatic testReset();
    checkVal("R1 status", statusWord, 16'h0000);
    checkVal("R1 ack", {15'd0, irqAck}, 16'd0);
    checkEn("R1 enables", 7'b1111111);
  endtask

  task automatic testLevels();
    writeWord(16'h0010); checkEn("R3 level0", 7'b0011111);
    checkVal("R12 write", statusWord, 16'h0010);
    dcoSrcUsed = 1'b0;
    writeWord(16'h0050); checkEn("R4 level1 src0", 7'b0011101);
    dcoSrcUsed = 1'b1; #1; checkEn("R4 level1 src1", 7'b0011111);
    dcoSrcUsed = 1'b0;
    writeWord(16'h0090); checkEn("R5 level2", 7'b0001011);
    writeWord(16'h00D0); checkEn("R6 level3", 7'b0001001);
    writeWord(16'h0030); checkEn("R7 level4", 7'b0000000);
    writeWord(16'h00F0); checkEn("R7 level4 scg set", 7'b0000000);
    writeWord(16'h00E0); checkEn("R2 active with mode bits", 7'b1111111);
  endtask

  task automatic testEntryReturn();
    writeWord(16'h00D9);
    @(negedge clk); irqReq = 1'b1;
    @(negedge clk); irqReq = 1'b0;
    checkVal("R8 ack", {15'd0, irqAck}, 16'd1);
    checkVal("R8 cleared", statusWord, 16'h0041);
    checkVal("R8 saved", savedWord, 16'h00D9);
    checkEn("R8 active after entry", 7'b1111111);
    @(negedge clk);
    checkVal("R8 ack one cycle", {15'd0, irqAck}, 16'd0);
    retiEn = 1'b1; retiWord = 16'h00C9;
    @(negedge clk); retiEn = 1'b0;
    checkVal("R11 edited word", statusWord, 16'h00C9);
    checkEn("R11 edited active", 7'b1111111);
    retiEn = 1'b1; retiWord = 16'h00D9; swWrEn = 1'b1; swWrData = 16'h0010;
    @(negedge clk); retiEn = 1'b0; swWrEn = 1'b0;
    checkVal("R12 return beats write", statusWord, 16'h00D9);
    checkEn("R11 back to level3", 7'b0001001);
  endtask

  task automatic testWakeGating();
    writeWord(16'h0038);
    @(negedge clk); irqReq = 1'b1;
    @(negedge clk);
    checkVal("R9 ignore ack", {15'd0, irqAck}, 16'd0);
    checkVal("R9 ignore status", statusWord, 16'h0038);
    irqExtReq = 1'b1; retiEn = 1'b1; retiWord = 16'h0010;
    @(negedge clk); irqReq = 1'b0; irqExtReq = 1'b0; retiEn = 1'b0;
    checkVal("R9 ext wakes", {15'd0, irqAck}, 16'd1);
    checkVal("R12 entry beats return", statusWord, 16'h0000);
    checkVal("R9 saved", savedWord, 16'h0038);
    writeWord(16'h0010);
    @(negedge clk); irqReq = 1'b1; irqExtReq = 1'b1;
    @(negedge clk);
    checkVal("R10 no gie ack", {15'd0, irqAck}, 16'd0);
    @(negedge clk); irqReq = 1'b0; irqExtReq = 1'b0;
    checkVal("R10 no gie status", statusWord, 16'h0010);
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLevels();
    testEntryReturn();
    testWakeGating();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule